// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Sequencer

This block produces the external bus timing of a small 8-bit processor, one T-state per clock period. A caller asks for one bus cycle by giving its kind (opcode fetch, memory read, memory write, I/O read or I/O write), a 16-bit address and, for writes, a data byte. The sequencer then runs the cycle on a multiplexed bus and drives these signals:

- the low address byte, then the data, on a shared 8-bit lane;
- the high address byte on its own lines;
- an address latch enable;
- active-low read and write strobes;
- a select that tells memory cycles from I/O cycles.

When the cycle ends, the block raises a one-clock done pulse. For cycles that read, the byte taken from the bus comes back with that pulse.

An instruction-level front end can also chain whole sequences of cycles without an idle gap between them:

- **Register move:** a single fetch.
- **Move-immediate:** a fetch, then one operand read.
- **Store-direct:** a fetch, two operand reads, then a write of an accumulator byte to the address those two reads returned.

All state advances on the falling clock edge, so every T-state starts there.

Both request ports follow valid/ready rules. A request is taken on the falling edge where valid and ready are both high. The caller must hold the request stable while ready is low. Ready is high only while the sequencer is idle and no instruction is running. If both ports are valid at once, the instruction port wins. The done pulses carry no back-pressure: they cannot be stalled and are present for exactly one clock. The shared lane is split into an output, an output enable and an input, so that a pad ring can build the bidirectional pin.

Top module: `bus_cycle_seq`

## Requirements
- R1: The cycle kind codes are 0 fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, and codes 5 to 7 act as memory read. A fetch lasts 4 T-states and every other kind lasts 3.
- R2: In T1, `ale` is high for that clock only. `bus_ad_out` carries address bits 7:0 with `bus_ad_oe` high, `addr_hi` carries bits 15:8, and both strobes are high.
- R3: For fetch, memory read and I/O read, `rd_n` is low in T2 and T3 and the lane is released (`bus_ad_oe` low). The byte on `bus_ad_in` at the falling edge that ends T3 is returned on `rsp_data`.
- R4: For both write kinds, `bus_ad_out` carries the write byte with `bus_ad_oe` high in T2 and T3, and `wr_n` is low in those two T-states. `rd_n` and `wr_n` are never low together.
- R5: In T4 of a fetch, neither strobe is low and the lane is released, while `addr_hi` still holds the address.
- R6: `io_m` is high for the I/O kinds (3, 4) and low for the memory kinds (0 to 2), and it stays constant through every T-state of a cycle.
- R7: `rsp_valid` is high for exactly one clock, the one that follows the final T-state of each cycle.
- R8: `req_ready` is high only while the sequencer is idle. A request held while busy waits, and its T1 follows the done clock of the running cycle.
- R9: `ins_kind` 0 runs a fetch at `ins_pc` (4 T-states). Kind 1 runs a fetch and a read at pc+1 (7 T-states). Kind 2 runs a fetch, reads at pc+1 and pc+2, then writes `ins_acc` to {byte from pc+2, byte from pc+1} (13 T-states). Kind 3 acts as kind 0. The cycles run back to back, and `ins_done` is high for one clock after the last T-state.
- R10: When both ports are valid at an idle edge, the instruction is taken. `req_ready` stays low until the instruction finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state advances on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Single-cycle request valid |
| req_ready | output | 1 | Single-cycle request accepted when high with valid |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte for write kinds |
| rsp_valid | output | 1 | One-clock done pulse after each cycle |
| rsp_data | output | 8 | Byte captured by the last reading cycle |
| ins_valid | input | 1 | Instruction request valid |
| ins_ready | output | 1 | Instruction request accepted when high with valid |
| ins_kind | input | 2 | Instruction code |
| ins_pc | input | 16 | Address of the opcode |
| ins_acc | input | 8 | Byte stored by store-direct |
| ins_done | output | 1 | One-clock pulse after the last cycle of an instruction |
| bus_ad_out | output | 8 | Multiplexed lane, outgoing value |
| bus_ad_oe | output | 1 | Multiplexed lane output enable |
| bus_ad_in | input | 8 | Multiplexed lane, incoming value |
| addr_hi | output | 8 | Upper address byte |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | High for I/O cycles, low for memory cycles |

## Verification
The hardest case to reach from the ports is the store-direct write. Its target address is built from a byte that arrives on the same falling edge that launches the write. A wrong pairing of bytes, or a one-edge slip, would only show up as a wrong address on the bus. The bench provides a memory model whose content is a known function of the address. This lets it predict the two operand bytes and the write target. It then compares every address latch pulse and the written data against that prediction. The same chained runs also count T-states from the first latch pulse up to the instruction done pulse. Any idle gap between chained cycles shows up as a wrong count.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4
  } cyc_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } ts_e;

  typedef enum logic [1:0] {
    INS_MOVR = 2'd0,
    INS_MVI  = 2'd1,
    INS_STA  = 2'd2
  } ins_e;

  // R1: unknown kind codes fall back to a memory read
  function automatic cyc_e decode_cyc(input logic [2:0] code);
    case (code)
      3'd0:    return CYC_FETCH;
      3'd2:    return CYC_MWR;
      3'd3:    return CYC_IORD;
      3'd4:    return CYC_IOWR;
      default: return CYC_MRD;
    endcase
  endfunction

  function automatic ins_e decode_ins(input logic [1:0] code);
    case (code)
      2'd1:    return INS_MVI;
      2'd2:    return INS_STA;
      default: return INS_MOVR;
    endcase
  endfunction

  function automatic logic cyc_reads(input cyc_e k);
    return (k == CYC_FETCH) || (k == CYC_MRD) || (k == CYC_IORD);
  endfunction

  function automatic logic cyc_writes(input cyc_e k);
    return (k == CYC_MWR) || (k == CYC_IOWR);
  endfunction

  function automatic logic cyc_is_io(input cyc_e k);
    return (k == CYC_IORD) || (k == CYC_IOWR);
  endfunction

  // number of bus cycles each instruction chains
  function automatic logic [2:0] ins_cycles(input ins_e op);
    case (op)
      INS_MVI: return 3'd2;
      INS_STA: return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/mcs_seq.sv
module mcs_seq
  import mcs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  cyc_e                go_kind,
  input  logic [2*DW-1:0]     go_addr,
  input  logic [DW-1:0]       go_wdata,
  input  logic [DW-1:0]       din,
  output logic                accept,
  output logic                last,
  output logic                idle,
  output ts_e                 ts,
  output cyc_e                kind,
  output logic [2*DW-1:0]     addr,
  output logic [DW-1:0]       wdata,
  output logic                done,
  output logic [DW-1:0]       rdata
);

  localparam int AW = 2 * DW;

  always_comb begin
    idle   = (ts == TS_IDLE);
    last   = ((ts == TS_T3) && (kind != CYC_FETCH)) || (ts == TS_T4);
    accept = go && (idle || last);
  end

  // every T-state begins on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts    <= TS_IDLE;
      kind  <= CYC_MRD;
      addr  <= '0;
      wdata <= '0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= last;
      if ((ts == TS_T3) && cyc_reads(kind)) rdata <= din;
      if (accept) begin
        ts    <= TS_T1;
        kind  <= go_kind;
        addr  <= go_addr;
        wdata <= go_wdata;
      end else begin
        case (ts)
          TS_T1:   ts <= TS_T2;
          TS_T2:   ts <= TS_T3;
          TS_T3:   ts <= (kind == CYC_FETCH) ? TS_T4 : TS_IDLE;
          default: ts <= TS_IDLE;
        endcase
      end
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  t4_fetch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == TS_T4) |-> ($past(ts) == TS_T3));

  logic unused_aw;
  assign unused_aw = (AW == 0);

endmodule

// File: rtl/mcs_bus_drv.sv
module mcs_bus_drv
  import mcs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ts_e               ts,
  input  cyc_e              kind,
  input  logic [2*DW-1:0]   addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     ad_out,
  output logic              ad_oe,
  output logic [DW-1:0]     a_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m
);

  localparam int AW = 2 * DW;

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    a_hi   = '0;
    ale    = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    io_m   = 1'b0;
    if (ts != TS_IDLE) begin
      a_hi = addr[AW-1:DW];
      io_m = cyc_is_io(kind);
    end
    case (ts)
      TS_T1: begin
        ad_out = addr[DW-1:0];
        ad_oe  = 1'b1;
        ale    = 1'b1;
      end
      TS_T2, TS_T3: begin
        if (cyc_writes(kind)) begin
          ad_out = wdata;
          ad_oe  = 1'b1;
          wr_n   = 1'b0;
        end else begin
          rd_n = 1'b0;
        end
      end
      default: ;
    endcase
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R2
  ale_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R6
  io_sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ts == TS_T2) || (ts == TS_T3) || (ts == TS_T4)) |-> $stable(io_m));

endmodule

// File: rtl/mcs_ins_ctl.sv
module mcs_ins_ctl
  import mcs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ins_e              start_kind,
  input  logic [2*DW-1:0]   start_pc,
  input  logic [DW-1:0]     start_acc,
  input  logic              seq_accept,
  input  logic              seq_last,
  input  logic [DW-1:0]     din,
  output logic              active,
  output logic              go,
  output cyc_e              go_kind,
  output logic [2*DW-1:0]   go_addr,
  output logic [DW-1:0]     go_wdata,
  output logic              ins_done
);

  localparam int AW = 2 * DW;

  ins_e          op;
  logic [AW-1:0] pc;
  logic [DW-1:0] acc;
  logic [DW-1:0] lo;
  logic [2:0]    n_issued;
  logic [2:0]    total;

  always_comb begin
    total    = ins_cycles(op);
    go       = active && (n_issued < total);
    go_kind  = CYC_MRD;
    go_addr  = pc + AW'(1);
    go_wdata = '0;
    case (n_issued)
      3'd2: go_addr = pc + AW'(2);
      3'd3: begin
        // high byte arrives on the very edge that launches the write
        go_kind  = CYC_MWR;
        go_addr  = {din, lo};
        go_wdata = acc;
      end
      default: ;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      op       <= INS_MOVR;
      pc       <= '0;
      acc      <= '0;
      lo       <= '0;
      n_issued <= '0;
      ins_done <= 1'b0;
    end else begin
      ins_done <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        op       <= start_kind;
        pc       <= start_pc;
        acc      <= start_acc;
        n_issued <= 3'd1;
      end else if (active) begin
        if (seq_last && (op == INS_STA) && (n_issued == 3'd2)) lo <= din;
        if (seq_last && (n_issued == total)) begin
          active   <= 1'b0;
          ins_done <= 1'b1;
        end else if (seq_accept) begin
          n_issued <= n_issued + 3'd1;
        end
      end
    end
  end

  // R9
  ins_done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_done |=> !ins_done);

  // R9
  ins_done_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_done |-> !active);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import mcs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [1:0]    ins_kind,
  input  logic [AW-1:0] ins_pc,
  input  logic [DW-1:0] ins_acc,
  output logic          ins_done,
  output logic [DW-1:0] bus_ad_out,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_in,
  output logic [DW-1:0] addr_hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          io_m
);

  logic          seq_go, seq_accept, seq_last, seq_idle;
  cyc_e          seq_kind, cur_kind;
  logic [AW-1:0] seq_addr, cur_addr;
  logic [DW-1:0] seq_wdata, cur_wdata;
  ts_e           ts;
  logic          ctl_active, ctl_go, ins_fire;
  cyc_e          ctl_kind;
  logic [AW-1:0] ctl_addr;
  logic [DW-1:0] ctl_wdata;

  always_comb begin
    ins_ready = seq_idle && !ctl_active;
    req_ready = seq_idle && !ctl_active && !ins_valid;
    ins_fire  = ins_valid && ins_ready;
    if (ctl_active) begin
      seq_go    = ctl_go;
      seq_kind  = ctl_kind;
      seq_addr  = ctl_addr;
      seq_wdata = ctl_wdata;
    end else if (ins_valid) begin
      seq_go    = ins_ready;
      seq_kind  = CYC_FETCH;
      seq_addr  = ins_pc;
      seq_wdata = '0;
    end else begin
      seq_go    = req_valid && req_ready;
      seq_kind  = decode_cyc(req_kind);
      seq_addr  = req_addr;
      seq_wdata = req_wdata;
    end
  end

  mcs_seq #(.DW(DW)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (seq_go),
    .go_kind  (seq_kind),
    .go_addr  (seq_addr),
    .go_wdata (seq_wdata),
    .din      (bus_ad_in),
    .accept   (seq_accept),
    .last     (seq_last),
    .idle     (seq_idle),
    .ts       (ts),
    .kind     (cur_kind),
    .addr     (cur_addr),
    .wdata    (cur_wdata),
    .done     (rsp_valid),
    .rdata    (rsp_data)
  );

  mcs_bus_drv #(.DW(DW)) i_drv (
    .clk    (clk),
    .rst_n  (rst_n),
    .ts     (ts),
    .kind   (cur_kind),
    .addr   (cur_addr),
    .wdata  (cur_wdata),
    .ad_out (bus_ad_out),
    .ad_oe  (bus_ad_oe),
    .a_hi   (addr_hi),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .io_m   (io_m)
  );

  mcs_ins_ctl #(.DW(DW)) i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ins_fire),
    .start_kind (decode_ins(ins_kind)),
    .start_pc   (ins_pc),
    .start_acc  (ins_acc),
    .seq_accept (seq_accept),
    .seq_last   (seq_last),
    .din        (bus_ad_in),
    .active     (ctl_active),
    .go         (ctl_go),
    .go_kind    (ctl_kind),
    .go_addr    (ctl_addr),
    .go_wdata   (ctl_wdata),
    .ins_done   (ins_done)
  );

  // R5
  t4_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == TS_T4) |-> (rd_n && wr_n && !bus_ad_oe));

  // R8
  ready_blocks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || !rd_n || !wr_n) |-> !req_ready);

  // R10
  ins_excludes_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> !req_ready);

endmodule

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, ins_valid = 1'b0;
  logic        req_ready, ins_ready, rsp_valid, ins_done;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0, ins_pc = '0;
  logic [7:0]  req_wdata = '0, ins_acc = '0;
  logic [1:0]  ins_kind = '0;
  logic [7:0]  rsp_data, bus_ad_out, bus_ad_in, addr_hi;
  logic        bus_ad_oe, ale, rd_n, wr_n, io_m;
  logic [15:0] lat_a = '0;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // bench memory: latched address selects the byte on the lane
  always @(posedge clk) if (ale) lat_a <= {addr_hi, bus_ad_out};
  assign bus_ad_in = memf(lat_a);

  bus_cycle_seq i_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_kind(ins_kind),
    .ins_pc(ins_pc), .ins_acc(ins_acc), .ins_done(ins_done),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .addr_hi(addr_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // kind, addr, wdata
  localparam logic [26:0] VECS [0:6] = '{
    {3'd0, 16'h1234, 8'h00},
    {3'd1, 16'hABCD, 8'h00},
    {3'd2, 16'h0F0F, 8'h5A},
    {3'd3, 16'h0081, 8'h00},
    {3'd4, 16'h00FE, 8'hC3},
    {3'd1, 16'hFFFF, 8'h00},
    {3'd6, 16'h2468, 8'h00}
  };

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd);
    logic rd, wr, io, fet;
    int len;
    string tag;
    fet = (k == 3'd0);
    wr  = (k == 3'd2) || (k == 3'd4);
    io  = (k == 3'd3) || (k == 3'd4);
    rd  = !wr;
    while (!req_ready) step();
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    step();
    req_valid = 1'b0;
    len = 0;
    while (!rsp_valid && len < 8) begin
      logic [4:0] e, got;
      logic mid;
      mid = (len == 1) || (len == 2);
      e   = {len == 0, !(rd && mid), !(wr && mid), io, (len == 0) || (wr && mid)};
      got = {ale, rd_n, wr_n, io_m, bus_ad_oe};
      tag = (len == 0) ? "R2" : (len == 3) ? "R5" : wr ? "R4" : "R3";
      chk(got == e, tag, "strobes {ale,rd_n,wr_n,io_m,oe}", got, e);
      chk(io_m == io, "R6", "io_m", io_m, io);
      if (len == 0) chk({addr_hi, bus_ad_out} == a, "R2", "T1 address", {addr_hi, bus_ad_out}, a);
      if (wr && mid) chk(bus_ad_out == wd, "R4", "write data", bus_ad_out, wd);
      if (len == 3) chk(addr_hi == a[15:8], "R5", "T4 high address", addr_hi, a[15:8]);
      len++;
      step();
    end
    chk(len == (fet ? 4 : 3), "R1", "T-state count", len, fet ? 4 : 3);
    if (rd) chk(rsp_data == memf(a), "R3", "read byte", rsp_data, memf(a));
    step();
    chk(!rsp_valid, "R7", "done pulse width", rsp_valid, 0);
  endtask

  task automatic run_ins(input logic [1:0] k, input logic [15:0] pc, input logic [7:0] acc);
    logic [15:0] exp_a [0:3];
    logic [15:0] got_a [0:3];
    int n_ale, n, n_cyc, exp_len, n_wr;
    logic [7:0] wr_data;
    n_cyc   = (k == 2'd1) ? 2 : (k == 2'd2) ? 4 : 1;
    exp_len = (k == 2'd1) ? 7 : (k == 2'd2) ? 13 : 4;
    exp_a[0] = pc; exp_a[1] = pc + 16'd1; exp_a[2] = pc + 16'd2;
    exp_a[3] = {memf(pc + 16'd2), memf(pc + 16'd1)};
    for (int i = 0; i < 4; i++) got_a[i] = '0;
    while (!ins_ready) step();
    ins_valid = 1'b1; ins_kind = k; ins_pc = pc; ins_acc = acc;
    step();
    ins_valid = 1'b0;
    chk(!req_ready, "R10", "req_ready during instruction", req_ready, 0);
    n = 0; n_ale = 0; n_wr = 0; wr_data = '0;
    while (!ins_done && n < 40) begin
      if (ale) begin
        if (n_ale < 4) got_a[n_ale] = {addr_hi, bus_ad_out};
        n_ale++;
      end
      if (!wr_n) begin n_wr++; wr_data = bus_ad_out; end
      n++;
      step();
    end
    chk(n == exp_len, "R9", "instruction T-states", n, exp_len);
    chk(n_ale == n_cyc, "R9", "cycle count", n_ale, n_cyc);
    for (int i = 0; i < 4; i++)
      if (i < n_cyc) chk(got_a[i] == exp_a[i], "R9", "cycle address", got_a[i], exp_a[i]);
    if (k == 2'd2) begin
      chk(n_wr == 2, "R9", "write strobe clocks", n_wr, 2);
      chk(wr_data == acc, "R9", "stored byte", wr_data, acc);
    end else begin
      chk(n_wr == 0, "R9", "no write", n_wr, 0);
    end
    step();
    chk(!ins_done, "R9", "ins_done width", ins_done, 0);
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    repeat (3) step();
    chk({ale, rd_n, wr_n, bus_ad_oe, rsp_valid, ins_done} == 6'b011000, "R2",
        "reset outputs", {ale, rd_n, wr_n, bus_ad_oe, rsp_valid, ins_done}, 6'b011000);
    chk(req_ready && ins_ready, "R8", "ready after reset", {req_ready, ins_ready}, 2'b11);
    rst_n = 1'b1;
    step();

    // R1..R7 over the vector table
    for (int v = 0; v < 7; v++) run_cycle(VECS[v][26:24], VECS[v][23:8], VECS[v][7:0]);

    // R8: request held through a busy cycle
    while (!req_ready) step();
    req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h4444;
    step();
    req_addr = 16'h5555;
    for (int i = 0; i < 3; i++) begin
      chk(!req_ready, "R8", "ready low while busy", req_ready, 0);
      step();
    end
    chk(rsp_valid && req_ready, "R8", "ready at done clock", {rsp_valid, req_ready}, 2'b11);
    step();
    chk(ale && {addr_hi, bus_ad_out} == 16'h5555, "R8", "held request starts",
        {addr_hi, bus_ad_out}, 16'h5555);
    req_valid = 1'b0;
    repeat (4) step();

    // R9
    run_ins(2'd0, 16'h0040, 8'h00);
    run_ins(2'd1, 16'h3000, 8'h00);
    run_ins(2'd2, 16'h1200, 8'hA5);
    run_ins(2'd3, 16'h0800, 8'h00);

    // R10: both ports valid at once
    while (!req_ready) step();
    req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h7777; req_wdata = 8'h11;
    ins_valid = 1'b1; ins_kind = 2'd0; ins_pc = 16'h0100;
    step();
    ins_valid = 1'b0;
    chk(ale && {addr_hi, bus_ad_out} == 16'h0100, "R10", "instruction wins",
        {addr_hi, bus_ad_out}, 16'h0100);
    chk(!req_ready, "R10", "req held off", req_ready, 0);
    for (int i = 0; i < 10 && !ins_done; i++) step();
    step();
    chk(ale && {addr_hi, bus_ad_out} == 16'h7777, "R10", "request runs after",
        {addr_hi, bus_ad_out}, 16'h7777);
    req_valid = 1'b0;
    repeat (5) step();
    finish_up();
  end

endmodule